// File: doc/BRIEF.md
# Supply Enable and Fault Mask Register Bank

This block sits inside a power-management controller. It keeps two byte-wide control registers behind a plain register port with an 8-bit address. One register is an interrupt mask for seven per-rail fault flags. The other holds a software enable for each of five supply rails. The port decodes one write strobe per cycle, and read data is a combinational function of the address.

Each rail is switched on only when both its software enable bit and its external enable pin are high. While a pin is held low, the bits it governs are driven back to 1. This means a later rising pin turns the rail on again, even if software had cleared the bit. The two LDO rails share one pin.

An undervoltage-lockout input reloads both registers to their defaults on the next clock edge. An asynchronous active-low reset does the same. The fault flags that the mask lets through are ORed together into an active-low interrupt, which is registered once.

Top module: `pmc_supply_regbank`

## Requirements
- R1: The mask register is at address 0x02 and resets to 0xC0. Bits 7..1 are read/write, and a write shows up on `rdata` the cycle after its clock edge. Mask bit n+1 belongs to `fault[n]`.
- R2: The enable register is at address 0x03 and resets to 0xFF. Bits 5..1 are read/write and enable the rails in this order: bit5 DCDC-A, bit4 DCDC-B, bit3 DCDC-C, bit2 LDO-B, bit1 LDO-A.
- R3: Unused bits read their default value and ignore writes: mask bit 0 reads 0, and enable bits 7, 6 and 0 read 1.
- R4: Any address other than 0x02 and 0x03 reads 0x00, and a write to it changes neither register.
- R5: When `uvlo` is high at a clock edge, both registers reload their defaults (0xC0 and 0xFF). This takes priority over a write in the same cycle.
- R6: When an enable pin is low at a clock edge, the bits it governs become 1, even if the same edge writes 0 to them. `dcdc_pin[2]`, `dcdc_pin[1]` and `dcdc_pin[0]` govern bits 5, 4 and 3. `ldo_pin` governs bits 2 and 1.
- R7: `rail_on[4:0]` is the AND of enable bits 5..1 with their pins, with no delay. `rail_on[4]` is DCDC-A and `rail_on[0]` is LDO-A.
- R8: `irq_n` is registered. After each edge it is 0 if the previous cycle had any `fault[n]` high with mask bit n+1 clear, and 1 otherwise. Fault flag order from bit 6 down is: power-fail, low-battery, DCDC-A, DCDC-B, DCDC-C, LDO-B, LDO-A.
- R9: While `rst_n` is low, the registers hold their defaults and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Undervoltage lockout; synchronous reload to defaults |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| dcdc_pin | input | 3 | Enable pins for DCDC-A, DCDC-B, DCDC-C (bit 2 down to 0) |
| ldo_pin | input | 1 | Shared enable pin for both LDO rails |
| fault | input | 7 | Fault flags, active high |
| rail_on | output | 5 | Effective rail enables |
| irq_n | output | 1 | Active-low interrupt |

## Verification
On every cycle, the assertions check four things:
- the undervoltage reload of both registers;
- the pin-low force of each enable bit;
- that a mask write lands;
- that the interrupt level follows the unmasked fault set of the previous cycle.

Only the bench's scenarios can show the externally visible cases:
- the unused-bit read values;
- that an unmapped write leaves the registers unchanged;
- the collision of a write with a low pin;
- that the live AND gating on `rail_on` follows the pins.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
    localparam int          DW          = 8;
    localparam int          AW          = 8;
    localparam logic [7:0]  ADDR_MASK   = 8'h02;
    localparam logic [7:0]  ADDR_ENCTL  = 8'h03;
    localparam logic [7:0]  MASK_DFLT   = 8'hC0;
    localparam logic [7:0]  ENCTL_DFLT  = 8'hFF;
    localparam int          N_FAULT     = 7;
    localparam int          EN_LO       = 1;
    localparam int          EN_HI       = 5;
    localparam int          N_RAIL      = EN_HI - EN_LO + 1;
endpackage

// File: rtl/rbk_mask_reg.sv
module rbk_mask_reg #(
    parameter int             DW   = 8,
    parameter int             AW   = 8,
    parameter logic [AW-1:0]  ADDR = 8'h02,
    parameter logic [DW-1:0]  DFLT = 8'hC0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uvlo,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask_q
);
    logic [DW-1:1] bits_q;
    logic          hit;

    assign hit = wr_en && (addr == ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= DFLT[DW-1:1];
        end else if (uvlo) begin
            bits_q <= DFLT[DW-1:1];
        end else if (hit) begin
            bits_q <= wdata[DW-1:1];
        end
    end

    assign mask_q = {bits_q, DFLT[0]};

    // R5: undervoltage reload of the mask
    a_r5_mask_uvlo: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (bits_q == DFLT[DW-1:1]));

    // R1: a mask write lands on the next edge
    a_r1_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !uvlo) |=> (bits_q == $past(wdata[DW-1:1])));
endmodule

// File: rtl/rbk_enctl_reg.sv
module rbk_enctl_reg #(
    parameter int             DW   = 8,
    parameter int             AW   = 8,
    parameter logic [AW-1:0]  ADDR = 8'h03,
    parameter logic [DW-1:0]  DFLT = 8'hFF,
    parameter int             LO   = 1,
    parameter int             HI   = 5,
    localparam int            NB   = HI - LO + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uvlo,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] pin_vec,
    output logic [DW-1:0] reg_q,
    output logic [NB-1:0] gated
);
    logic [NB-1:0] bits_q;
    logic          hit;

    assign hit = wr_en && (addr == ADDR);

    for (genvar i = 0; i < NB; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[i] <= DFLT[LO+i];
            end else if (uvlo) begin
                bits_q[i] <= DFLT[LO+i];
            end else if (!pin_vec[i]) begin
                bits_q[i] <= 1'b1;
            end else if (hit) begin
                bits_q[i] <= wdata[LO+i];
            end
        end

        // R6: a low pin restores its bit on the next edge
        a_r6_pin_restore: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_vec[i] |=> bits_q[i]);
    end

    always_comb begin
        reg_q = DFLT;
        reg_q[HI:LO] = bits_q;
    end

    assign gated = bits_q & pin_vec;

    // R5: undervoltage reload of the enable bits
    a_r5_enctl_uvlo: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (bits_q == DFLT[HI:LO]));
endmodule

// File: rtl/rbk_irq.sv
module rbk_irq #(
    parameter int NF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] fault,
    input  logic [NF-1:0] mask_bits,
    output logic          irq_n
);
    logic [NF-1:0] live;

    assign live = fault & ~mask_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= ~(|live);
        end
    end

    // R8: interrupt follows the unmasked fault set one cycle later
    a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fault & ~mask_bits)) |=> !irq_n);
    a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault & ~mask_bits) == '0) |=> irq_n);
endmodule

// File: rtl/pmc_supply_regbank.sv
module pmc_supply_regbank
    import rbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uvlo,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [2:0]        dcdc_pin,
    input  logic              ldo_pin,
    input  logic [N_FAULT-1:0] fault,
    output logic [N_RAIL-1:0] rail_on,
    output logic              irq_n
);
    logic [DW-1:0]     mask_q;
    logic [DW-1:0]     enctl_q;
    logic [N_RAIL-1:0] pin_vec;

    assign pin_vec = {dcdc_pin[2], dcdc_pin[1], dcdc_pin[0], ldo_pin, ldo_pin};

    rbk_mask_reg #(
        .DW(DW), .AW(AW), .ADDR(ADDR_MASK), .DFLT(MASK_DFLT)
    ) u_mask (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .mask_q(mask_q)
    );

    rbk_enctl_reg #(
        .DW(DW), .AW(AW), .ADDR(ADDR_ENCTL), .DFLT(ENCTL_DFLT),
        .LO(EN_LO), .HI(EN_HI)
    ) u_enctl (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .pin_vec(pin_vec),
        .reg_q(enctl_q), .gated(rail_on)
    );

    rbk_irq #(
        .NF(N_FAULT)
    ) u_irq (
        .clk(clk), .rst_n(rst_n), .fault(fault),
        .mask_bits(mask_q[N_FAULT:1]), .irq_n(irq_n)
    );

    always_comb begin
        unique case (addr)
            ADDR_MASK:  rdata = mask_q;
            ADDR_ENCTL: rdata = enctl_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: tb/sim_pmc_supply_regbank.sv
module sim_pmc_supply_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uvlo = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] dcdc_pin = 3'b111;
    logic       ldo_pin = 1'b1;
    logic [6:0] fault = 7'h00;
    logic [4:0] rail_on;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    string scn = "R9";

    logic [7:0] m_mask = 8'hC0;
    logic [7:0] m_en   = 8'hFF;
    logic       m_irq  = 1'b1;

    always #4 clk = ~clk;

    pmc_supply_regbank u0 (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dcdc_pin(dcdc_pin), .ldo_pin(ldo_pin),
        .fault(fault), .rail_on(rail_on), .irq_n(irq_n)
    );

    // Behavioural reference, updated on each edge from the driven inputs
    always @(posedge clk) begin
        logic [7:0] pins;
        logic       any;
        if (!rst_n) begin
            m_mask = 8'hC0; m_en = 8'hFF; m_irq = 1'b1;
        end else begin
            any = 1'b0;
            for (int n = 0; n < 7; n++)
                if (fault[n] && !m_mask[n+1]) any = 1'b1;
            m_irq = !any;
            pins = {2'b11, dcdc_pin[2], dcdc_pin[1], dcdc_pin[0], ldo_pin, ldo_pin, 1'b1};
            if (uvlo) begin
                m_mask = 8'hC0; m_en = 8'hFF;
            end else begin
                if (wr_en && addr == 8'h02) m_mask = {wdata[7:1], 1'b0};
                if (wr_en && addr == 8'h03) m_en = {2'b11, wdata[5:1], 1'b1};
                for (int b = 1; b <= 5; b++)
                    if (!pins[b]) m_en[b] = 1'b1;
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        if (addr == 8'h02) return m_mask;
        if (addr == 8'h03) return m_en;
        return 8'h00;
    endfunction

    function automatic logic [4:0] exp_rail();
        logic [4:0] p;
        p = {dcdc_pin[2], dcdc_pin[1], dcdc_pin[0], ldo_pin, ldo_pin};
        return m_en[5:1] & p;
    endfunction

    task automatic cmp(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s/%s got=%02h exp=%02h t=%0t", scn, tag, got, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp((addr == 8'h02) ? "R1" : (addr == 8'h03) ? "R2" : "R4", rdata, exp_rd());
        cmp("R7", {3'b0, rail_on}, {3'b0, exp_rail()});
        cmp("R8", {7'b0, irq_n}, {7'b0, m_irq});
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: held in reset, then read defaults
        addr = 8'h02; cyc(); cyc();
        addr = 8'h03; cyc();
        rst_n = 1'b1;
        scn = "R1"; addr = 8'h02; cyc();
        wr(8'h02, 8'h55); cyc();
        wr(8'h02, 8'hFE); cyc();
        scn = "R3"; wr(8'h02, 8'h01); cyc();
        scn = "R2"; wr(8'h03, 8'h00); addr = 8'h03; cyc();
        wr(8'h03, 8'h14); cyc();
        scn = "R3"; wr(8'h03, 8'h00); cyc();
        // R4: unmapped address
        scn = "R4"; wr(8'h04, 8'hAA); addr = 8'h04; cyc();
        wr(8'hFF, 8'h00); addr = 8'h02; cyc(); addr = 8'h03; cyc();
        // R7: pin gating with bits set and cleared
        scn = "R7"; wr(8'h03, 8'h2A);
        dcdc_pin = 3'b010; ldo_pin = 1'b1; cyc();
        // R6: pins low restore bits
        scn = "R6"; dcdc_pin = 3'b000; ldo_pin = 1'b0; cyc();
        dcdc_pin = 3'b111; ldo_pin = 1'b1; cyc();
        wr(8'h03, 8'h00); cyc();
        ldo_pin = 1'b0; wr(8'h03, 8'h00); cyc();
        ldo_pin = 1'b1; dcdc_pin = 3'b101; wr(8'h03, 8'h00); cyc();
        dcdc_pin = 3'b111; cyc();
        // R8: faults with various masks
        scn = "R8"; wr(8'h02, 8'h00);
        fault = 7'h01; cyc(); cyc();
        fault = 7'h00; cyc(); cyc();
        wr(8'h02, 8'h04); fault = 7'h02; cyc(); cyc();
        fault = 7'h60; cyc(); cyc();
        wr(8'h02, 8'hC0); cyc(); cyc();
        wr(8'h02, 8'hFE); fault = 7'h7F; cyc(); cyc();
        wr(8'h02, 8'hFC); cyc(); cyc();
        // R5: undervoltage reload beats a write
        scn = "R5"; wr(8'h03, 8'h00); addr = 8'h03; cyc();
        uvlo = 1'b1; wr(8'h03, 8'h00); uvlo = 1'b0; cyc();
        addr = 8'h02; cyc();
        uvlo = 1'b1; wr(8'h02, 8'h00); uvlo = 1'b0; cyc(); cyc();
        fault = 7'h00; cyc();
        // R9: asynchronous reset mid-run
        scn = "R9"; wr(8'h02, 8'h12); rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule